// File: doc/BRIEF.md
# Serial Control Word Loader

This block receives configuration words over a three-wire serial link (data, shift clock, latch strobe) and stores each word in one of four configuration registers. The serial wires come from outside the system clock domain. Each of them passes through a synchronizer, and its rising edges are detected on the system clock. A 24-bit shift register takes in one data bit on every rising edge of the shift clock, most significant bit first. A rising edge on the latch strobe then copies the 22 upper bits of the frame into the register that the two lowest bits of the frame select.

The selector value 0 addresses the reference divider register, 1 the counter register, 2 the function register and 3 the initialization register. A write to the initialization register also writes the same payload into the function register. The top module presents the four stored payloads unchanged, together with the decoded fields that the rest of the synthesizer reads: the reference division ratio, the antibacklash width code, the lock precision flag, the swallow count A, the main count B, the output mux select and the prescaler select.

Top module: `ctrl_word_loader`

## Requirements
- R1: After a synchronous active-low reset, every stored payload is zero except the reference divider payload, which holds 1. The reference ratio output therefore reads 1 and all other fields read 0.
- R2: On each rising shift-clock edge, the shifter moves one bit in at the least significant end. The last 24 bits shifted before a latch edge form the frame, with the first of them as bit 23. Bits shifted earlier than those 24 are discarded.
- R3: Selector 0 (frame bits 1:0 = 00) stores frame bits 23:2 as the reference payload. The reference ratio is frame bits 15:2, the antibacklash code is bits 17:16, and the lock precision flag is bit 20.
- R4: Selector 1 (bits 1:0 = 01) stores the counter payload. Swallow count A is frame bits 7:2 and main count B is frame bits 20:8.
- R5: Selector 2 (bits 1:0 = 10) stores the function payload. The mux select is frame bits 8:6 and the prescaler select is frame bits 23:22.
- R6: Selector 3 (bits 1:0 = 11) stores the payload in the initialization register and in the function register together.
- R7: A latch edge leaves every register it does not address unchanged.
- R8: Shift-clock activity without a latch rising edge leaves every stored payload and decoded field unchanged.
- R9: A detected edge of a serial input lasts exactly one system clock cycle. The addressed register takes its new value at the third system clock edge after the latch strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_latch | input | 1 | Latch strobe, asynchronous |
| ref_word | output | 22 | Stored reference divider payload |
| cnt_word | output | 22 | Stored counter payload |
| func_word | output | 22 | Stored function payload |
| init_word | output | 22 | Stored initialization payload |
| ref_ratio | output | 14 | Reference division ratio |
| abw_code | output | 2 | Antibacklash width code |
| lock_prec | output | 1 | Lock precision flag |
| swallow_a | output | 6 | Swallow count A |
| main_b | output | 13 | Main count B |
| mux_sel | output | 3 | Output mux select |
| presc_sel | output | 2 | Prescaler select |

## Verification
The assertions assume that each serial input stays stable for at least three system clock cycles between changes. They also assume that data is steady before its shift-clock edge, so that data and clock leave the synchronizer in the right order. The stimulus keeps every serial level for three system cycles and changes data only while the shift clock is low. It raises the latch strobe only after the shift clock has been low for a full half period. The register-hold properties also assume that frames are not corrupted by a latch edge during shifting, and the driver never overlaps the two.

// File: rtl/cwl_pkg.sv
// Package: shared widths, selector codes and field positions for the
// serial control word loader. Assumes a frame whose two low bits select
// the destination and whose upper bits form the payload.
package cwl_pkg;
    localparam int FRAME_W = 24;
    localparam int SEL_W   = 2;
    localparam int PAY_W   = FRAME_W - SEL_W;
    localparam int NUM_REG = 1 << SEL_W;

    // Destination codes carried in the frame's low bits
    typedef enum logic [SEL_W-1:0] {
        DST_REF  = 2'd0,
        DST_CNT  = 2'd1,
        DST_FUNC = 2'd2,
        DST_INIT = 2'd3
    } dest_e;

    // Field positions inside the payload (payload bit = frame bit - 2)
    localparam int REF_RATIO_LSB = 0;
    localparam int REF_RATIO_W   = 14;
    localparam int ABW_LSB       = 14;
    localparam int ABW_W         = 2;
    localparam int LOCKP_BIT     = 18;
    localparam int SWA_LSB       = 0;
    localparam int SWA_W         = 6;
    localparam int MAINB_LSB     = 6;
    localparam int MAINB_W       = 13;
    localparam int MUX_LSB       = 4;
    localparam int MUX_W         = 3;
    localparam int PRESC_LSB     = 20;
    localparam int PRESC_W       = 2;

    typedef logic [PAY_W-1:0] payload_t;
endpackage

// File: rtl/cwl_sync_edge.sv
// Module: multi-bit synchronizer with rising-edge detection.
// Each bit of async_i passes a STAGES-deep flop chain into the clk domain.
// rise_o pulses for one cycle when the synchronized level goes from 0 to 1.
// Assumes inputs hold each level for more than STAGES+1 clk cycles.
module cwl_sync_edge #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o
);
    logic [STAGES-1:0][N-1:0] pipe;
    logic [N-1:0]             last;
    logic                     past_ok;

    // First flop of the chain captures the raw inputs
    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= async_i;
    end

    // Remaining stages of the chain
    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[g] <= '0;
                else        pipe[g] <= pipe[g-1];
            end
        end
    endgenerate

    // Remembers the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) last <= '0;
        else        last <= pipe[STAGES-1];
    end

    assign level_o = pipe[STAGES-1];
    assign rise_o  = pipe[STAGES-1] & ~last;

    // Marks cycles after reset where history is valid
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R9: a detected edge never lasts two cycles
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/cwl_shifter.sv
// Module: frame shift register. On each shift strobe, the register moves up
// one place and the new data bit enters at bit 0, so the first bit of a frame
// ends at the top. Assumes shift_en is a single-cycle strobe.
module cwl_shifter #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             din,
    output logic [WIDTH-1:0] frame_o
);
    logic [WIDTH-1:0] sr;
    logic             past_ok;

    // Shift one bit in at the low end, MSB of the frame arrives first
    always_ff @(posedge clk) begin
        if (!rst_n)        sr <= '0;
        else if (shift_en) sr <= {sr[WIDTH-2:0], din};
    end

    assign frame_o = sr;

    // Marks cycles after reset where history is valid
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R2: each strobe moves the older bits up and appends the sampled bit
    assert_shift_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && shift_en |=> (frame_o == {$past(frame_o[WIDTH-2:0]), $past(din)}));

    // R8: with no strobe the register keeps its content
    assert_shift_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !shift_en |=> $stable(frame_o));
endmodule

// File: rtl/cwl_dest_regs.sv
// Module: destination register bank. On a load strobe, the frame's low bits
// select a register, and the upper bits are written into it. A write to the
// initialization slot also writes the function slot. Slot 0 resets to 1,
// and the others reset to 0. Assumes load is a single-cycle strobe.
module cwl_dest_regs
    import cwl_pkg::*;
#(
    parameter int FW = FRAME_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load,
    input  logic [FW-1:0]                  frame_i,
    output logic [NUM_REG-1:0][PAY_W-1:0]  regs_o
);
    logic [SEL_W-1:0]   sel;
    payload_t           payload;
    logic [NUM_REG-1:0] we;
    logic               past_ok;

    assign sel     = frame_i[SEL_W-1:0];
    assign payload = frame_i[FW-1:SEL_W];

    genvar i;
    generate
        for (i = 0; i < NUM_REG; i++) begin : g_slot
            localparam payload_t RST_VAL = (i == int'(DST_REF)) ? payload_t'(1) : '0;
            // Write enable: direct address, plus the function slot mirroring init
            if (i == int'(DST_FUNC)) begin : g_mirror
                assign we[i] = load && ((sel == DST_FUNC) || (sel == DST_INIT));
            end else begin : g_plain
                assign we[i] = load && (sel == SEL_W'(i));
            end

            // Holds one configuration payload
            always_ff @(posedge clk) begin
                if (!rst_n)     regs_o[i] <= RST_VAL;
                else if (we[i]) regs_o[i] <= payload;
            end

            // R8: without a load strobe the slot keeps its value
            assert_hold_no_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
                past_ok && !load |=> $stable(regs_o[i]));
        end
    endgenerate

    // Marks cycles after reset where history is valid
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R3: a reference write stores the frame's payload
    assert_ref_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && load && (sel == DST_REF) |=> regs_o[DST_REF] == $past(payload));

    // R6: an init write leaves function and init equal
    assert_init_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && load && (sel == DST_INIT) |=> regs_o[DST_FUNC] == regs_o[DST_INIT]);

    // R7: a counter write leaves the reference slot alone
    assert_untouched_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && load && (sel != DST_REF) |=> $stable(regs_o[DST_REF]));
endmodule

// File: rtl/ctrl_word_loader.sv
// Module: top of the serial control word loader. Synchronizes the three
// serial wires, shifts frames on shift-clock rises, loads a destination
// register on latch rises and decodes the stored fields.
// Assumes the serial wires are slow compared with clk.
module ctrl_word_loader
    import cwl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ser_clk,
    input  logic                   ser_data,
    input  logic                   ser_latch,
    output logic [PAY_W-1:0]       ref_word,
    output logic [PAY_W-1:0]       cnt_word,
    output logic [PAY_W-1:0]       func_word,
    output logic [PAY_W-1:0]       init_word,
    output logic [REF_RATIO_W-1:0] ref_ratio,
    output logic [ABW_W-1:0]       abw_code,
    output logic                   lock_prec,
    output logic [SWA_W-1:0]       swallow_a,
    output logic [MAINB_W-1:0]     main_b,
    output logic [MUX_W-1:0]       mux_sel,
    output logic [PRESC_W-1:0]     presc_sel
);
    localparam int IDX_CLK = 0;
    localparam int IDX_DAT = 1;
    localparam int IDX_LAT = 2;

    logic [2:0]                    lvl;
    logic [2:0]                    rise;
    logic [FRAME_W-1:0]            frame;
    logic [NUM_REG-1:0][PAY_W-1:0] regs;

    cwl_sync_edge #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_latch, ser_data, ser_clk}),
        .level_o (lvl),
        .rise_o  (rise)
    );

    cwl_shifter #(.WIDTH(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (rise[IDX_CLK]),
        .din      (lvl[IDX_DAT]),
        .frame_o  (frame)
    );

    cwl_dest_regs #(.FW(FRAME_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (rise[IDX_LAT]),
        .frame_i (frame),
        .regs_o  (regs)
    );

    // Decode stored payloads into the fields that the synthesizer uses
    always_comb begin
        ref_word  = regs[DST_REF];
        cnt_word  = regs[DST_CNT];
        func_word = regs[DST_FUNC];
        init_word = regs[DST_INIT];
        ref_ratio = ref_word[REF_RATIO_LSB +: REF_RATIO_W];
        abw_code  = ref_word[ABW_LSB +: ABW_W];
        lock_prec = ref_word[LOCKP_BIT];
        swallow_a = cnt_word[SWA_LSB +: SWA_W];
        main_b    = cnt_word[MAINB_LSB +: MAINB_W];
        mux_sel   = func_word[MUX_LSB +: MUX_W];
        presc_sel = func_word[PRESC_LSB +: PRESC_W];
    end
endmodule

// File: tb/ctrl_word_loader_bench.sv
// Scoreboard bench: the driver shifts frames and pushes the expected register
// state. The monitor pops each item once the design has settled and compares it.
module ctrl_word_loader_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_latch = 1'b0;
    logic [21:0] ref_word, cnt_word, func_word, init_word;
    logic [13:0] ref_ratio;
    logic [1:0]  abw_code, presc_sel;
    logic        lock_prec;
    logic [5:0]  swallow_a;
    logic [12:0] main_b;
    logic [2:0]  mux_sel;

    int n_cmp = 0, n_bad = 0, cycles = 0;
    bit finished = 0;

    typedef struct {
        logic [21:0] r, c, f, i;
        string       tag;
    } exp_t;
    exp_t q[$];
    logic [21:0] m_ref = 22'd1, m_cnt = '0, m_fn = '0, m_init = '0;

    always #4 clk = ~clk;

    ctrl_word_loader u_ctrl_word_loader (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_latch(ser_latch), .ref_word(ref_word), .cnt_word(cnt_word),
        .func_word(func_word), .init_word(init_word), .ref_ratio(ref_ratio),
        .abw_code(abw_code), .lock_prec(lock_prec), .swallow_a(swallow_a),
        .main_b(main_b), .mux_sel(mux_sel), .presc_sel(presc_sel)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Shift nbits of data (top bit first), optionally strobe the latch
    task automatic send(input logic [63:0] bits, input int nbits, input bit latch);
        for (int k = nbits - 1; k >= 0; k--) begin
            @(negedge clk); ser_clk = 1'b0; ser_data = bits[k];
            repeat (3) @(negedge clk);
            ser_clk = 1'b1;
            repeat (3) @(negedge clk);
        end
        ser_clk = 1'b0;
        repeat (3) @(negedge clk);
        if (latch) begin
            ser_latch = 1'b1;
            repeat (3) @(negedge clk);
            ser_latch = 1'b0;
        end
    endtask

    // Update the reference model from a frame and push the expected state
    task automatic apply(input logic [23:0] w, input string tag);
        case (w[1:0])
            2'd0: m_ref = w[23:2];
            2'd1: m_cnt = w[23:2];
            2'd2: m_fn  = w[23:2];
            default: begin m_init = w[23:2]; m_fn = w[23:2]; end
        endcase
        q.push_back('{m_ref, m_cnt, m_fn, m_init, tag});
    endtask

    task automatic push_same(input string tag);
        q.push_back('{m_ref, m_cnt, m_fn, m_init, tag});
    endtask

    // Monitor: wait for the design to settle, then compare raw and decoded outputs
    initial begin
        forever begin
            wait (q.size() > 0);
            repeat (6) @(negedge clk);
            begin
                exp_t e;
                e = q.pop_front();
                check({ref_word, cnt_word, func_word, init_word} == {e.r, e.c, e.f, e.i},
                      e.tag, "raw words",
                      64'({ref_word[15:0], cnt_word[15:0], func_word[15:0], init_word[15:0]}),
                      64'({e.r[15:0], e.c[15:0], e.f[15:0], e.i[15:0]}));
                check({ref_ratio, abw_code, lock_prec, swallow_a, main_b, mux_sel, presc_sel} ==
                      {e.r[13:0], e.r[15:14], e.r[18], e.c[5:0], e.c[18:6], e.f[6:4], e.f[21:20]},
                      e.tag, "decoded fields",
                      64'({ref_ratio, abw_code, lock_prec, swallow_a, main_b, mux_sel, presc_sel}),
                      64'({e.r[13:0], e.r[15:14], e.r[18], e.c[5:0], e.c[18:6], e.f[6:4], e.f[21:20]}));
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        check(ref_word == 22'd1 && cnt_word == '0 && func_word == '0 && init_word == '0,
              "R1", "reset words", 64'(ref_word), 64'd1);
        check(ref_ratio == 14'd1 && main_b == '0 && mux_sel == '0 && presc_sel == '0,
              "R1", "reset fields", 64'(ref_ratio), 64'd1);
        // R3: reference write, ratio max, abw and precision set
        send(64'({2'b00, 1'b1, 2'b00, 2'b11, 14'h3FFF, 2'b00}), 24, 1);
        apply({2'b00, 1'b1, 2'b00, 2'b11, 14'h3FFF, 2'b00}, "R3");
        // R4 and R7: counter write leaves reference intact
        send(64'({3'b101, 13'h1ABC, 6'h2D, 2'b01}), 24, 1);
        apply({3'b101, 13'h1ABC, 6'h2D, 2'b01}, "R4 R7");
        // R5: function write
        send(64'({2'b10, 13'h0, 3'b110, 2'b01, 2'b10}), 24, 1);
        apply({2'b10, 13'h0, 3'b110, 2'b01, 2'b10}, "R5");
        // R6: init write mirrors into function
        send(64'({2'b01, 13'h155, 3'b011, 2'b10, 2'b11}), 24, 1);
        apply({2'b01, 13'h155, 3'b011, 2'b10, 2'b11}, "R6");
        // R8: shifting a full frame without latch changes nothing
        send(64'(24'hFFFFFC), 24, 0);
        push_same("R8");
        // R2: 30 bits shifted, only the final 24 form the frame
        send({34'h0, 6'b111111, 24'h00_1238}, 30, 1);
        apply(24'h00_1238, "R2");
        // R7: a function-only write leaves init alone
        send(64'(24'h40_0042), 24, 1);
        apply(24'h40_0042, "R7");
        // R3: reference ratio written back to minimum value
        send(64'(24'h00_0004), 24, 1);
        apply(24'h00_0004, "R3");
        // R9: update lands three clk edges after latch rises
        send(64'(24'hA5_5A01), 24, 0);
        @(negedge clk); ser_latch = 1'b1;
        repeat (2) @(negedge clk);
        check(cnt_word == m_cnt, "R9", "before third edge", 64'(cnt_word), 64'(m_cnt));
        @(negedge clk);
        check(cnt_word == 22'(24'hA55A01 >> 2), "R9", "after third edge",
              64'(cnt_word), 64'(24'hA55A01 >> 2));
        ser_latch = 1'b0;
        m_cnt = 22'(24'hA55A01 >> 2);
        push_same("R9");
        wait (q.size() == 0);
        repeat (10) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule